// File: doc/BRIEF.md
# Vector End-Around-Carry Checksum Unit

The unit folds a 128-bit data vector into a 32-bit checksum of the kind used by Internet protocols. It splits each vector into four 32-bit words. A seed word taken from a second vector starts the running total. The four data words are then added to that total one by one. Whenever an addition carries out of bit 31, the carry is added straight back into bit 0 before the next word is taken.

A start pulse captures both operands while the unit is idle. The unit then processes one data word per clock. A one-cycle done pulse marks the moment the result vector becomes valid. The result vector carries the checksum in a single word, and every other word is zero. It keeps its value until the next operation finishes, so a new operation can be launched in the same cycle that the previous one reports done.

Top module: `vcksm_unit`

## Requirements
- R1: A vector is treated as four 32-bit words. Word 0 is bits [127:96], word 1 is bits [95:64], word 2 is bits [63:32] and word 3 is bits [31:0].
- R2: The running total starts from word 1 of the seed vector `seed_vec_i`. The other seed words have no effect.
- R3: Data words 0, 1, 2 and 3 of `data_vec_i` are added in that order. After each 32-bit addition, its carry-out is added back into the 32-bit sum. For example, a seed of 0xFFFFFFFF with data words 1, 0, 0, 0 yields 0x00000001, all-ones operands yield 0xFFFFFFFF, and all-zero operands yield 0.
- R4: The final sum appears in word 1 of `result_o`. Words 0, 2 and 3 are zero.
- R5: A start sampled at a rising edge while idle makes `done_o` high for exactly one cycle, after the 4th following rising edge.
- R6: `result_o` changes only at the edge that raises `done_o`, and holds its value between completions.
- R7: A start seen while an operation is in progress is ignored. Operand changes after capture have no effect.
- R8: A start asserted during the cycle in which `done_o` is high is accepted and begins a new operation.
- R9: While `rst_ni` is low, `done_o` is low and `result_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch request, captures operands when idle |
| data_vec_i | input | 128 | Data vector, four words summed |
| seed_vec_i | input | 128 | Seed vector, word 1 used |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 128 | Checksum in word 1, other words zero |

## Verification
Two events can fall in the same cycle: completion of one operation and acceptance of the next. The bench provokes this by raising start during the cycle in which done is high, with fresh operands. It then checks two things. First, the first result stays on the output through the following four busy cycles. Second, the second checksum appears exactly four edges after the new start was taken. A companion case raises start in the middle of a busy phase. For that case, the bench checks that the pending result is unaffected and that no extra done pulse follows.

// File: rtl/vcksm_pkg.sv
package vcksm_pkg;
  parameter int unsigned WORD_W    = 32;
  parameter int unsigned NUM_WORDS = 4;
  parameter int unsigned SEED_IDX  = 1;
  parameter int unsigned DEST_IDX  = 1;
  localparam int unsigned VEC_W    = WORD_W * NUM_WORDS;
  localparam int unsigned IDX_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [VEC_W-1:0]  vec_t;
endpackage

// File: rtl/vcksm_word_sel.sv
module vcksm_word_sel #(
  parameter int unsigned W     = 32,
  parameter int unsigned N     = 4,
  parameter int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N*W-1:0] vec_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [W-1:0]   word_o
);
  logic [W-1:0] words [N];

  // word 0 sits in the most significant slice
  for (genvar k = 0; k < N; k++) begin : g_split
    assign words[k] = vec_i[(N-1-k)*W +: W];
  end

  assign word_o = words[idx_i];
endmodule

// File: rtl/vcksm_eac_add.sv
module vcksm_eac_add #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] acc_i,
  input  logic [W-1:0] word_i,
  output logic [W-1:0] sum_o
);
  logic [W:0] raw;

  // carry-out folded back into bit 0; the fold cannot carry again
  always_comb begin
    raw   = {1'b0, acc_i} + {1'b0, word_i};
    sum_o = raw[W-1:0] + {{(W-1){1'b0}}, raw[W]};
  end

  // R3
  always_comb begin
    eac_nonzero_chk: assert (((acc_i | word_i) == '0) || (sum_o != '0))
      else $error("end-around sum collapsed to zero");
  end
endmodule

// File: rtl/vcksm_pack.sv
module vcksm_pack #(
  parameter int unsigned W   = 32,
  parameter int unsigned N   = 4,
  parameter int unsigned POS = 1
) (
  input  logic [W-1:0]   word_i,
  output logic [N*W-1:0] vec_o
);
  for (genvar k = 0; k < N; k++) begin : g_place
    if (k == POS) begin : g_hit
      assign vec_o[(N-1-k)*W +: W] = word_i;
    end else begin : g_zero
      assign vec_o[(N-1-k)*W +: W] = '0;
    end
  end
endmodule

// File: rtl/vcksm_unit.sv
module vcksm_unit
  import vcksm_pkg::*;
(
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [127:0] data_vec_i,
  input  logic [127:0] seed_vec_i,
  output logic         done_o,
  output logic [127:0] result_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_WORDS - 1);
  localparam logic [IDX_W-1:0] SEED_SEL = IDX_W'(SEED_IDX);

  vec_t             data_q;
  word_t            acc_q;
  logic [IDX_W-1:0] idx_q;
  logic             busy_q;
  logic             done_q;
  vec_t             res_q;

  word_t seed_w, cur_w, sum_w;
  vec_t  packed_w;
  logic  accept_w;

  assign accept_w = start_i && !busy_q;

  vcksm_word_sel #(.W(WORD_W), .N(NUM_WORDS), .IDX_W(IDX_W)) i_seed_sel (
    .vec_i (seed_vec_i),
    .idx_i (SEED_SEL),
    .word_o(seed_w)
  );

  vcksm_word_sel #(.W(WORD_W), .N(NUM_WORDS), .IDX_W(IDX_W)) i_data_sel (
    .vec_i (data_q),
    .idx_i (idx_q),
    .word_o(cur_w)
  );

  vcksm_eac_add #(.W(WORD_W)) i_add (
    .acc_i (acc_q),
    .word_i(cur_w),
    .sum_o (sum_w)
  );

  vcksm_pack #(.W(WORD_W), .N(NUM_WORDS), .POS(DEST_IDX)) i_pack (
    .word_i(sum_w),
    .vec_o (packed_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      acc_q  <= '0;
      idx_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      res_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept_w) begin
        data_q <= data_vec_i;
        acc_q  <= seed_w;
        idx_q  <= '0;
        busy_q <= 1'b1;
      end else if (busy_q) begin
        acc_q <= sum_w;
        if (idx_q == LAST_IDX) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          res_q  <= packed_w;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end
    end
  end

  assign done_o   = done_q;
  assign result_o = res_q;

  // R5
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);

  // R5
  done_after_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && idx_q == LAST_IDX) |=> done_q);

  // R7
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && idx_q != LAST_IDX) |=> (busy_q && !done_q));

  // R8
  accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_w |=> (busy_q && idx_q == '0));

  // R6
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_q && idx_q == LAST_IDX) |=> $stable(res_q));
endmodule

// File: tb/test_vcksm_unit.sv
module test_vcksm_unit;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         start_i = 1'b0;
  logic [127:0] data_vec_i = '0;
  logic [127:0] seed_vec_i = '0;
  logic         done_o;
  logic [127:0] result_o;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  vcksm_unit i_vcksm_unit (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .data_vec_i(data_vec_i),
    .seed_vec_i(seed_vec_i),
    .done_o    (done_o),
    .result_o  (result_o)
  );

  always #5 clk_i = ~clk_i;

  function automatic logic [127:0] ref_cksm(input logic [127:0] a, input logic [127:0] b);
    logic [31:0] acc;
    logic [32:0] s;
    acc = b[95:64];
    for (int k = 0; k < 4; k++) begin
      s   = {1'b0, acc} + {1'b0, a[(3-k)*32 +: 32]};
      acc = s[31:0] + {31'b0, s[32]};
    end
    return {32'b0, acc, 64'b0};
  endfunction

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  // start at one negedge, sampled at next posedge (P0); done after P4
  task automatic run_op(input logic [127:0] a, input logic [127:0] b);
    logic [127:0] exp;
    exp = ref_cksm(a, b);
    @(negedge clk_i);
    start_i = 1'b1; data_vec_i = a; seed_vec_i = b;
    @(negedge clk_i);
    start_i = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk_i);
      check("R5 early done", {127'b0, done_o}, 128'd0);
    end
    @(negedge clk_i);
    check("R5 done", {127'b0, done_o}, 128'd1);
    check("R3 R4 result", result_o, exp);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [127:0] a1, b1, a2, b2, e1, e2;
    void'($urandom(32'h5EED_0042));

    // R9
    @(negedge clk_i);
    check("R9 done in reset", {127'b0, done_o}, 128'd0);
    check("R9 result in reset", result_o, 128'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R3 corners
    run_op({4{32'hFFFF_FFFF}}, {4{32'hFFFF_FFFF}});
    check("R3 all ones", result_o, {32'b0, 32'hFFFF_FFFF, 64'b0});
    run_op('0, '0);
    check("R3 all zero", result_o, 128'd0);
    run_op({32'h1, 96'b0}, {32'b0, 32'hFFFF_FFFF, 64'b0});
    check("R3 fold to one", result_o, {32'b0, 32'h1, 64'b0});

    // R1 R2: only seed word 1 counts, other seed words ignored
    run_op({32'h0, 32'h0, 32'h0, 32'h0000_0007}, {32'hAAAA_AAAA, 32'h10, 32'h5555_5555, 32'h1234_5678});
    check("R1 R2 seed word", result_o, {32'b0, 32'h17, 64'b0});

    // R6: hold after done
    @(negedge clk_i);
    check("R6 done low", {127'b0, done_o}, 128'd0);
    check("R6 hold", result_o, {32'b0, 32'h17, 64'b0});

    // R7: start during busy ignored, operand changes ignored
    a1 = rnd128(); b1 = rnd128(); a2 = rnd128(); b2 = rnd128();
    e1 = ref_cksm(a1, b1);
    @(negedge clk_i);
    start_i = 1'b1; data_vec_i = a1; seed_vec_i = b1;
    @(negedge clk_i);
    start_i = 1'b0;
    @(negedge clk_i);
    start_i = 1'b1; data_vec_i = a2; seed_vec_i = b2;
    @(negedge clk_i);
    start_i = 1'b0;
    @(negedge clk_i);
    @(negedge clk_i);
    check("R7 done", {127'b0, done_o}, 128'd1);
    check("R7 first result kept", result_o, e1);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk_i);
      check("R7 no extra done", {127'b0, done_o}, 128'd0);
    end
    check("R7 result unchanged", result_o, e1);

    // R8: start in the done cycle is accepted
    a1 = rnd128(); b1 = rnd128(); a2 = rnd128(); b2 = rnd128();
    e1 = ref_cksm(a1, b1); e2 = ref_cksm(a2, b2);
    run_op(a1, b1);
    start_i = 1'b1; data_vec_i = a2; seed_vec_i = b2;
    @(negedge clk_i);
    start_i = 1'b0;
    check("R8 R6 first held", result_o, e1);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk_i);
      check("R8 early done", {127'b0, done_o}, 128'd0);
      check("R8 R6 first held busy", result_o, e1);
    end
    @(negedge clk_i);
    check("R8 second done", {127'b0, done_o}, 128'd1);
    check("R8 second result", result_o, e2);

    // random sweep
    for (int n = 0; n < 200; n++) begin
      run_op(rnd128(), rnd128());
    end

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule